// File: doc/BRIEF.md
# Delayed-Pulse Integrator with Weighted Readout

This block stands in, on a sampled clock, for a time-domain integrator followed by a weighted counter. Time is cut into frames of `FRAME_TICKS` clock ticks. Each frame is divided into `INTEG_N` equal slots of `FRAME_TICKS/INTEG_N` ticks. One input pulse arrives per frame, starting at the frame's first tick. Its width is measured in ticks and limited to one slot. The block emits a pulse train in which slot 0 carries the live pulse. Each later slot s carries a replica of the pulse from s frames earlier. Every replica is therefore pushed back by one more frame plus one more slot each time it is repeated, so copies never collide. A pulse that enters in frame f is present in frames f to f+INTEG_N-1 and is gone from frame f+INTEG_N onward.

At the close of every frame, the block adds up the widths of all copies that are in view. Each width is scaled by a gain that shrinks the older the copy is. The sum is rounded down to an integer and presented with a one-cycle strobe. The gains taper the influence of old copies. Without them, the output would dip every time a wide pulse, such as the first one after the loop starts from zero, leaves the window.

Control is a two-state machine. `ST_CAPTURE` covers slot 0, where the live pulse is measured and passed through. `ST_REPLAY` covers slots 1 to INTEG_N-1, where stored widths are played back. Transition `CAPTURE_TO_REPLAY` fires on the last tick of slot 0. Transition `REPLAY_TO_CAPTURE` fires on the last tick of the frame. Reset enters `ST_CAPTURE`.

Top module: `pulse_echo_integrator`

## Requirements
- R1: While reset is low, and in the first cycle after it, `train_out`, `sum_valid`, `sum_clip` and `frame_sum` are all 0.
- R2: In slot 0 of a frame, `train_out` repeats `pulse_in` one clock later, for at most the first slot-width ticks of high input in that frame.
- R3: In slot s (1 to INTEG_N-1) of frame f, `train_out` is high for the first w ticks of the slot and low after them. Here w is the clipped width of the pulse of frame f-s, or 0 if that frame did not exist since reset.
- R4: A pulse's last replica lies in slot INTEG_N-1 of the frame INTEG_N-1 frames after its arrival; no later frame shows it.
- R5: The gain of the copy aged s frames is floor((INTEG_N-s)*10/INTEG_N) tenths, held as an 8-bit value. For INTEG_N=10, this gives 10, 9, 8, 7, 6, 5, 4, 3, 2, 1 tenths from the newest to the oldest copy.
- R6: `sum_valid` is high for exactly one cycle, one clock after the last tick of each frame. `frame_sum` then equals floor(sum of width x gain-in-tenths / 10) over the copies of that frame, and holds until the next strobe.
- R7: A pulse wider than one slot is counted as one slot wide in every use. `sum_clip` is high together with that frame's strobe, and low at all other times.
- R8: Reset in mid-run empties the stored widths, so frames after it replay zero width for every slot that would refer to a frame from before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset; the frame starts at the first tick after release |
| pulse_in | input | 1 | Input pulse, high from the first tick of the frame |
| train_out | output | 1 | OR-combined pulse train, live pulse plus delayed replicas |
| frame_sum | output | SUM_W | Weighted width sum of the last completed frame |
| sum_valid | output | 1 | One-cycle strobe marking a new `frame_sum` |
| sum_clip | output | 1 | The frame just closed had an input pulse longer than a slot |

## Verification
Every tick of `pulse_in` shows up on `train_out` one clock later, whether it is passed through in slot 0 or replayed from storage. The frame result and its strobe appear one clock after the frame's last tick. The bench drives each tick's input on a falling edge, lets one rising edge process it, and reads the outputs at the next falling edge. So every comparison is made against the tick just driven. The reference keeps a per-frame list of clipped widths and derives, for every tick, the expected train bit from the slot and position. On frame-final ticks it also derives the expected strobe, sum and clip flag.

// File: rtl/pei_pkg.sv
package pei_pkg;

    typedef enum logic [0:0] {
        ST_CAPTURE = 1'b0,
        ST_REPLAY  = 1'b1
    } pei_state_e;

    // gain in tenths for a copy that has been delayed `age` times
    function automatic logic [7:0] slot_weight(input int unsigned age, input int unsigned n);
        return 8'(((n - age) * 10) / n);
    endfunction

    function automatic int unsigned weight_total(input int unsigned n);
        int unsigned acc;
        acc = 0;
        for (int unsigned a = 0; a < n; a++) acc += int'(slot_weight(a, n));
        return acc;
    endfunction

endpackage

// File: rtl/pei_timebase.sv
module pei_timebase #(
    parameter int SLOT_TICKS = 4,
    parameter int SLOTS      = 10,
    parameter int POS_W      = 2,
    parameter int SLOT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [POS_W-1:0]  pos,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_end,
    output logic              frame_end
);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(SLOT_TICKS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    assign slot_end  = (pos == LAST_POS);
    assign frame_end = slot_end && (slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            slot <= '0;
        end else if (slot_end) begin
            pos  <= '0;
            slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end else begin
            pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/pei_meter.sv
module pei_meter #(
    parameter int SLOT_TICKS = 4,
    parameter int WID_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             frame_end,
    output logic [WID_W-1:0] count,
    output logic             keep,
    output logic [WID_W-1:0] final_w,
    output logic             final_clip
);
    localparam logic [WID_W-1:0] FULL = WID_W'(SLOT_TICKS);

    logic clip_q;
    logic over;

    assign keep       = pulse_in && (count < FULL);
    assign over       = pulse_in && (count == FULL);
    assign final_w    = count + WID_W'(keep);
    assign final_clip = clip_q | over;

    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            count  <= '0;
            clip_q <= 1'b0;
        end else begin
            if (keep) count  <= count + 1'b1;
            if (over) clip_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pei_history.sv
module pei_history #(
    parameter int DEPTH = 9,
    parameter int WID_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [WID_W-1:0]            din,
    output logic [DEPTH-1:0][WID_W-1:0] taps
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        logic [WID_W-1:0] src;
        if (k == 0) begin : g_head
            assign src = din;
        end else begin : g_link
            assign src = taps[k-1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n)        taps[k] <= '0;
            else if (shift_en) taps[k] <= src;
        end
    end
endmodule

// File: rtl/pei_weighter.sv
module pei_weighter
    import pei_pkg::*;
#(
    parameter int N     = 10,
    parameter int WID_W = 3,
    parameter int ACC_W = 9,
    parameter int SUM_W = 9
) (
    input  logic [WID_W-1:0]            cur_w,
    input  logic [N-2:0][WID_W-1:0]     taps,
    output logic [SUM_W-1:0]            sum
);
    logic [ACC_W-1:0] acc;

    always_comb begin
        acc = ACC_W'(cur_w) * ACC_W'(slot_weight(0, N));
        for (int k = 0; k < N - 1; k++) begin
            acc = acc + ACC_W'(taps[k]) * ACC_W'(slot_weight(k + 1, N));
        end
        sum = SUM_W'(acc / ACC_W'(10));
    end
endmodule

// File: rtl/pulse_echo_integrator.sv
module pulse_echo_integrator
    import pei_pkg::*;
#(
    parameter int FRAME_TICKS = 40,
    parameter int INTEG_N     = 10,
    parameter int SUM_W       = $clog2(FRAME_TICKS * 10 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    output logic             train_out,
    output logic [SUM_W-1:0] frame_sum,
    output logic             sum_valid,
    output logic             sum_clip
);
    localparam int SLOT_TICKS = FRAME_TICKS / INTEG_N;
    localparam int DEPTH      = INTEG_N - 1;
    localparam int WID_W      = $clog2(SLOT_TICKS + 1);
    localparam int POS_W      = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
    localparam int SLOT_W     = $clog2(INTEG_N);
    localparam int ACC_W      = $clog2(SLOT_TICKS * 10 * INTEG_N + 1);

    logic [POS_W-1:0]            pos_q;
    logic [SLOT_W-1:0]           slot_idx;
    logic                        slot_end;
    logic                        frame_end;
    logic [WID_W-1:0]            meter_w;
    logic                        keep;
    logic [WID_W-1:0]            final_w;
    logic                        final_clip;
    logic [DEPTH-1:0][WID_W-1:0] taps;
    logic [SUM_W-1:0]            sum_next;
    logic                        replay_bit;
    pei_state_e                  state_q, state_d;

    pei_timebase #(
        .SLOT_TICKS(SLOT_TICKS), .SLOTS(INTEG_N), .POS_W(POS_W), .SLOT_W(SLOT_W)
    ) u_time (
        .clk(clk), .rst_n(rst_n), .pos(pos_q), .slot(slot_idx),
        .slot_end(slot_end), .frame_end(frame_end)
    );

    pei_meter #(.SLOT_TICKS(SLOT_TICKS), .WID_W(WID_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .frame_end(frame_end),
        .count(meter_w), .keep(keep), .final_w(final_w), .final_clip(final_clip)
    );

    pei_history #(.DEPTH(DEPTH), .WID_W(WID_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .shift_en(frame_end), .din(final_w), .taps(taps)
    );

    pei_weighter #(.N(INTEG_N), .WID_W(WID_W), .ACC_W(ACC_W), .SUM_W(SUM_W)) u_weigh (
        .cur_w(final_w), .taps(taps), .sum(sum_next)
    );

    // replica bit for the slot being played back
    always_comb begin
        replay_bit = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(slot_idx) == k + 1) replay_bit = (WID_W'(pos_q) < taps[k]);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CAPTURE: if (slot_end)  state_d = ST_REPLAY;
            ST_REPLAY:  if (frame_end) state_d = ST_CAPTURE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CAPTURE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            train_out <= 1'b0;
            frame_sum <= '0;
            sum_valid <= 1'b0;
            sum_clip  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CAPTURE: train_out <= keep;
                ST_REPLAY:  train_out <= replay_bit;
            endcase
            sum_valid <= frame_end;
            sum_clip  <= frame_end && final_clip;
            if (frame_end) frame_sum <= sum_next;
        end
    end
endmodule

// File: rtl/pei_checker.sv
module pei_checker
    import pei_pkg::*;
#(
    parameter int SLOT_TICKS = 4,
    parameter int INTEG_N    = 10,
    parameter int SUM_W      = 9,
    parameter int WID_W      = 3,
    parameter int SLOT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sum_valid,
    input logic              sum_clip,
    input logic [SUM_W-1:0]  frame_sum,
    input pei_state_e        state_q,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [WID_W-1:0]  meter_w
);
    localparam int MAX_SUM = (SLOT_TICKS * int'(weight_total(INTEG_N))) / 10;

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |=> !sum_valid);

    a_r6_sum_held: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_valid |-> $stable(frame_sum));

    a_r6_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> (int'(frame_sum) <= MAX_SUM));

    a_r7_clip_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sum_clip |-> sum_valid);

    a_r7_width_limit: assert property (@(posedge clk) disable iff (!rst_n)
        int'(meter_w) <= SLOT_TICKS);

    a_r3_capture_in_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == '0) == (state_q == ST_CAPTURE));
endmodule

bind pulse_echo_integrator pei_checker #(
    .SLOT_TICKS(SLOT_TICKS), .INTEG_N(INTEG_N), .SUM_W(SUM_W),
    .WID_W(WID_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sum_valid(sum_valid), .sum_clip(sum_clip),
    .frame_sum(frame_sum), .state_q(state_q), .slot_idx(slot_idx), .meter_w(meter_w)
);

// File: tb/tb_pulse_echo_integrator.sv
module tb_pulse_echo_integrator;
    localparam int P     = 40;
    localparam int N     = 10;
    localparam int W     = P / N;
    localparam int SUM_W = $clog2(P * 10 + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse_in = 1'b0;
    logic             train_out;
    logic [SUM_W-1:0] frame_sum;
    logic             sum_valid;
    logic             sum_clip;

    int checks = 0;
    int errors = 0;

    int raw [30] = '{4, 2, 0, 3, 1, 4, 6, 40, 0, 1, 2, 3, 4, 0, 0, 3, 2, 1, 4, 0, 0, 0,
                     3, 4, 1, 0, 2, 5, 4, 1};

    pulse_echo_integrator #(.FRAME_TICKS(P), .INTEG_N(N), .SUM_W(SUM_W)) dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .train_out(train_out),
        .frame_sum(frame_sum), .sum_valid(sum_valid), .sum_clip(sum_clip)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int clipw(input int w);
        return (w > W) ? W : w;
    endfunction

    // R5: gain in tenths for a copy of age s
    function automatic int gain(input int s);
        return ((N - s) * 10) / N;
    endfunction

    task automatic check_idle(input string tag);
        chk({tag, " train"}, int'(train_out), 0);
        chk({tag, " valid"}, int'(sum_valid), 0);
        chk({tag, " clip"},  int'(sum_clip),  0);
        chk({tag, " sum"},   int'(frame_sum), 0);
    endtask

    // frames base..base+nfr-1 of raw, history empty at start of the segment
    task automatic run_seg(input int base, input int nfr, input bit after_reset);
        for (int f = 0; f < nfr; f++) begin
            for (int t = 0; t < P; t++) begin
                int s, p, exp_bit, acc;
                s = t / W;
                p = t % W;
                rst_n    = 1'b1;
                pulse_in = (t < raw[base + f]);
                if (s == 0)          exp_bit = (p < clipw(raw[base + f])) ? 1 : 0;
                else if (f - s >= 0) exp_bit = (p < clipw(raw[base + f - s])) ? 1 : 0;
                else                 exp_bit = 0;
                @(negedge clk);
                if (s == 0)               chk("R2 live slot", int'(train_out), exp_bit);
                else if (f - s < 0 && after_reset) chk("R8 cleared replay", int'(train_out), exp_bit);
                else if (s == N - 1)      chk("R4 oldest replica", int'(train_out), exp_bit);
                else                      chk("R3 replica slot", int'(train_out), exp_bit);
                chk("R6 strobe", int'(sum_valid), (t == P - 1) ? 1 : 0);
                if (t == P - 1) begin
                    acc = 0;
                    for (int a = 0; a < N; a++)
                        if (f - a >= 0) acc += clipw(raw[base + f - a]) * gain(a);
                    chk("R5 R6 weighted sum", int'(frame_sum), acc / 10);
                    chk("R7 clip flag", int'(sum_clip), (raw[base + f] > W) ? 1 : 0);
                end else begin
                    chk("R7 clip idle", int'(sum_clip), 0);
                end
            end
        end
    endtask

    initial begin
        #(64'd200000 * 8);
        errors++;
        $display("FAIL watchdog actual 0 expected 1 (run did not finish)");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        run_seg(0, 22, 1'b0);
        rst_n    = 1'b0;
        pulse_in = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R1 R8 mid reset");
        run_seg(22, 8, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule